// File: doc/BRIEF.md
# Select-Pin Clock Divider Bank with Test Mode

This block drives a bank of seven output clocks (CPU, memory, 66-class, PCI, 48-class, reference and APIC), each with its own output enable. A two-bit select input picks one of four modes. In the off mode every enable is low, so all outputs float at the pads. In test mode each output is a fixed integer division of a test clock applied on the crystal input pin. In the two normal modes each output passes a clock supplied by a synthesiser outside this block. The two normal modes differ only in which CPU-rate source reaches the CPU output.

The select value is registered on the rising edge of the test clock. Any change of select restarts every test-mode divider at once, so the divided outputs start again from a common phase and no output gives a short pulse. The divide-by-3 output uses both clock edges to keep a 50% duty cycle.

Top module: `clk_mode_bank`

## Requirements
- R1: After a rising test-clock edge that samples select 00, every bit of `oe_o` and `clk_o` is 0.
- R2: In test mode (select 01), the CPU (bit 0), memory (bit 1) and 48-class (bit 4) outputs are the test clock divided by 2. Each is high for one test period and low for the next.
- R3: In test mode the 66-class output (bit 2) is the test clock divided by 3. It is high for 1.5 test periods, from a rising edge to the falling edge in the middle of the next period, and low for 1.5 periods.
- R4: In test mode the PCI (bit 3) and APIC (bit 6) outputs are the test clock divided by 6, high for 3 periods and low for 3. The reference output (bit 5) equals the test clock.
- R5: In select 10, the CPU output follows `cpu_lo_i`, the memory output follows `mem_i`, and the 66-class, PCI, 48-class, reference and APIC outputs follow their own source inputs.
- R6: In select 11, the CPU output follows `cpu_hi_i`, and every other output behaves as in select 10.
- R7: A new select value takes effect only at a rising test-clock edge. At the edge that applies a change, all divided outputs go low for one full test period. At the next rising edge the /2, /3 and /6 outputs all rise together, and after that they rise together every 6 periods.
- R8: While `rst_n` is low (asynchronous, active low), the block is in the off mode with all dividers idle. The first rising edge after release applies the current select.
- R9: The bit order of `clk_o` and `oe_o` is: 0 CPU, 1 memory, 2 66-class, 3 PCI, 4 48-class, 5 reference, 6 APIC. In select 01, 10 and 11, all seven enable bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock from the crystal input pin; it also clocks the select register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Mode select: 00 off, 01 test, 10 low CPU rate, 11 high CPU rate |
| cpu_lo_i | input | 1 | Lower-rate CPU source clock |
| cpu_hi_i | input | 1 | Higher-rate CPU source clock |
| mem_i | input | 1 | Memory source clock |
| c66_i | input | 1 | 66-class source clock |
| pci_i | input | 1 | PCI source clock |
| c48_i | input | 1 | 48-class source clock |
| ref_i | input | 1 | Reference source clock |
| apic_i | input | 1 | APIC source clock |
| clk_o | output | 7 | Output clocks, in the bit order given in R9 |
| oe_o | output | 7 | Output enables; 0 means the pad is in high impedance |

## Verification
The assertions assume that `sel_i` is stable around every rising edge of the test clock and that the test clock runs freely, so restart and mode capture happen only at those edges. They also assume the normal-mode sources are free-running signals that do not change at the sampling instants. The bench drives the select only on falling test-clock edges. It toggles every source on half-nanosecond offsets, while all output samples fall on whole nanoseconds, so no sample coincides with an input change.

// File: rtl/clkbank_pkg.sv
`timescale 1ns/100ps
package clkbank_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_LO   = 2'b10,
    MODE_HI   = 2'b11
  } mode_e;

  localparam int NUM_OUT  = 7;
  localparam int IDX_CPU  = 0;
  localparam int IDX_MEM  = 1;
  localparam int IDX_C66  = 2;
  localparam int IDX_PCI  = 3;
  localparam int IDX_C48  = 4;
  localparam int IDX_REF  = 5;
  localparam int IDX_APIC = 6;

  // Test-mode division factor of each output slot
  function automatic int out_ratio(int idx);
    case (idx)
      IDX_C66:            return 3;
      IDX_PCI, IDX_APIC:  return 6;
      IDX_REF:            return 1;
      default:            return 2;
    endcase
  endfunction

  // Number of whole source periods the divided clock stays high
  function automatic int high_span(int ratio);
    return ratio / 2;
  endfunction

endpackage

// File: rtl/clkbank_mode_reg.sv
`timescale 1ns/100ps
module clkbank_mode_reg
  import clkbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  output mode_e      mode_o,
  output logic       restart_o
);

  mode_e mode_q;

  assign restart_o = (sel_i != mode_q);
  assign mode_o    = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_e'(sel_i);
  end

  AST_MODE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (mode_o == mode_e'($past(sel_i)))); // R7

endmodule

// File: rtl/clkbank_divn.sv
`timescale 1ns/100ps
module clkbank_divn
  import clkbank_pkg::*;
#(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic div_o
);

  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(RATIO - 1);
  localparam logic [CW-1:0] SPAN_V = CW'(high_span(RATIO));

  logic [CW-1:0] cnt_q;

  // Idle phase is the last count, so outputs are low until the first edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= LAST_V;
    else if (restart_i)      cnt_q <= LAST_V;
    else if (cnt_q == LAST_V) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  generate
    if ((RATIO % 2) == 1) begin : g_odd
      localparam logic [CW-1:0] PRE_V = CW'(high_span(RATIO) - 1);
      logic tail_q;
      // Extends the high phase by half a period on the falling edge
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) tail_q <= 1'b0;
        else        tail_q <= (cnt_q == PRE_V);
      end
      assign div_o = (cnt_q < SPAN_V) | (tail_q & (cnt_q == SPAN_V));
    end else begin : g_even
      assign div_o = (cnt_q < SPAN_V);
    end
  endgenerate

  AST_IDLE_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !div_o); // R7

endmodule

// File: rtl/clkbank_out_mux.sv
`timescale 1ns/100ps
module clkbank_out_mux
  import clkbank_pkg::*;
(
  input  mode_e              mode_i,
  input  logic [NUM_OUT-1:0] test_div_i,
  input  logic [NUM_OUT-1:0] norm_i,
  input  logic               cpu_hi_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] oe_o
);

  always_comb begin
    clk_o = '0;
    oe_o  = '0;
    case (mode_i)
      MODE_TEST: begin
        clk_o = test_div_i;
        oe_o  = '1;
      end
      MODE_LO, MODE_HI: begin
        clk_o = norm_i;
        if (mode_i == MODE_HI) clk_o[IDX_CPU] = cpu_hi_i;
        oe_o  = '1;
      end
      default: begin
        clk_o = '0;
        oe_o  = '0;
      end
    endcase
  end

endmodule

// File: rtl/clk_mode_bank.sv
`timescale 1ns/100ps
module clk_mode_bank
  import clkbank_pkg::*;
(
  input  logic       test_clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       cpu_lo_i,
  input  logic       cpu_hi_i,
  input  logic       mem_i,
  input  logic       c66_i,
  input  logic       pci_i,
  input  logic       c48_i,
  input  logic       ref_i,
  input  logic       apic_i,
  output logic [6:0] clk_o,
  output logic [6:0] oe_o
);

  mode_e              mode_w;
  logic               restart_w;
  logic [NUM_OUT-1:0] test_div_w;
  logic [NUM_OUT-1:0] norm_w;

  clkbank_mode_reg u_mode (
    .clk       (test_clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .mode_o    (mode_w),
    .restart_o (restart_w)
  );

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
      if (out_ratio(i) == 1) begin : g_pass
        assign test_div_w[i] = test_clk;
      end else begin : g_div
        clkbank_divn #(.RATIO(out_ratio(i))) u_div (
          .clk       (test_clk),
          .rst_n     (rst_n),
          .restart_i (restart_w),
          .div_o     (test_div_w[i])
        );
      end
    end
  endgenerate

  // CPU slot carries the low-rate source; the mux swaps in the high one
  assign norm_w = {apic_i, ref_i, c48_i, pci_i, c66_i, mem_i, cpu_lo_i};

  clkbank_out_mux u_mux (
    .mode_i     (mode_w),
    .test_div_i (test_div_w),
    .norm_i     (norm_w),
    .cpu_hi_i   (cpu_hi_i),
    .clk_o      (clk_o),
    .oe_o       (oe_o)
  );

  AST_OFF_QUIET: assert property (@(posedge test_clk) disable iff (!rst_n)
    (sel_i == 2'b00) |=> ((oe_o == '0) && (clk_o == '0))); // R1

  AST_DIV2_ALTERNATES: assert property (@(posedge test_clk) disable iff (!rst_n)
    test_div_w[IDX_CPU] |=> !test_div_w[IDX_CPU]); // R2

  AST_DIV3_SHORT_SAMPLE: assert property (@(posedge test_clk) disable iff (!rst_n)
    $rose(test_div_w[IDX_C66]) |=> !test_div_w[IDX_C66]); // R3

  AST_DIV_ALIGN: assert property (@(posedge test_clk) disable iff (!rst_n)
    $rose(test_div_w[IDX_PCI]) |-> ($rose(test_div_w[IDX_CPU]) && $rose(test_div_w[IDX_C66]))); // R7

  AST_LO_SOURCES: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(sel_i) == 2'b10)) |-> ((clk_o[IDX_CPU] == cpu_lo_i) && (clk_o[IDX_MEM] == mem_i))); // R5

  AST_HI_SOURCES: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(sel_i) == 2'b11)) |-> ((clk_o[IDX_CPU] == cpu_hi_i) && (oe_o == '1))); // R6

endmodule

// File: tb/clk_mode_bank_tb_top.sv
`timescale 1ns/100ps
module clk_mode_bank_tb_top;

  logic       test_clk = 1'b0;
  logic       rst_n    = 1'b0;
  logic [1:0] sel_i    = 2'b01;
  logic cpu_lo_i = 0, cpu_hi_i = 0, mem_i = 0, c66_i = 0;
  logic pci_i = 0, c48_i = 0, ref_i = 0, apic_i = 0;
  logic [6:0] clk_o, oe_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  clk_mode_bank dut_i (
    .test_clk (test_clk), .rst_n (rst_n), .sel_i (sel_i),
    .cpu_lo_i (cpu_lo_i), .cpu_hi_i (cpu_hi_i), .mem_i (mem_i),
    .c66_i (c66_i), .pci_i (pci_i), .c48_i (c48_i), .ref_i (ref_i),
    .apic_i (apic_i), .clk_o (clk_o), .oe_o (oe_o)
  );

  always #10 test_clk = ~test_clk;

  // Sources toggle on half-ns offsets, away from every sample instant
  initial begin #0.5; forever #7  cpu_lo_i = ~cpu_lo_i; end
  initial begin #0.5; forever #5  cpu_hi_i = ~cpu_hi_i; end
  initial begin #0.5; forever #11 mem_i    = ~mem_i;    end
  initial begin #0.5; forever #13 c66_i    = ~c66_i;    end
  initial begin #0.5; forever #17 pci_i    = ~pci_i;    end
  initial begin #0.5; forever #19 c48_i    = ~c48_i;    end
  initial begin #0.5; forever #23 ref_i    = ~ref_i;    end
  initial begin #0.5; forever #29 apic_i   = ~apic_i;   end

  function automatic int ratio_of(int idx);
    case (idx)
      0, 1, 4: return 2;
      2:       return 3;
      3, 6:    return 6;
      default: return 1;
    endcase
  endfunction

  function automatic string req_of(int idx);
    case (idx)
      0, 1, 4: return "R2";
      2:       return "R3";
      default: return "R4";
    endcase
  endfunction

  // Half-period index h counted from the first rising edge after restart
  function automatic logic exp_bit(int idx, int k, int half);
    int r = ratio_of(idx);
    int h = 2 * (k - 1) + half;
    return ((h % (2 * r)) < r);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic apply_sel(logic [1:0] v);
    @(negedge test_clk);
    sel_i = v;
    @(posedge test_clk);
  endtask

  // Called at the rising edge that applied select 01
  task automatic check_test_window(int nper);
    #5;
    for (int idx = 0; idx < 7; idx++)
      if (ratio_of(idx) != 1) chk("R7", "divided low after restart", clk_o[idx], 1'b0);
    chk("R4", "reference high in first half", clk_o[5], 1'b1);
    chk("R9", "enables in test mode", oe_o, 7'h7f);
    #10;
    chk("R4", "reference low in second half", clk_o[5], 1'b0);
    for (int k = 1; k <= nper; k++) begin
      @(posedge test_clk);
      for (int half = 0; half < 2; half++) begin
        if (half == 0) #5; else #10;
        for (int idx = 0; idx < 7; idx++)
          chk(req_of(idx), $sformatf("slot %0d period %0d half %0d", idx, k, half),
              clk_o[idx], exp_bit(idx, k, half));
        if (k % 6 == 1 && half == 0)
          chk("R7", "joint rise of divided outputs", clk_o & 7'h5f, 7'h5f);
      end
    end
  endtask

  task automatic run_normal(logic [1:0] v, string req);
    apply_sel(v);
    chk("R9", "enables in normal mode", oe_o, 7'h7f);
    repeat (40) begin
      logic [6:0] exp;
      #3;
      exp = {apic_i, ref_i, c48_i, pci_i, c66_i, mem_i, (v == 2'b11) ? cpu_hi_i : cpu_lo_i};
      chk(req, "normal source routing", clk_o, exp);
    end
  endtask

  task automatic run_off();
    apply_sel(2'b00);
    repeat (20) begin
      #3;
      chk("R1", "off clocks", clk_o, 7'h00);
      chk("R1", "off enables", oe_o, 7'h00);
    end
  endtask

  task automatic run_reset();
    #25;
    chk("R8", "enables in reset", oe_o, 7'h00);
    chk("R8", "clocks in reset", clk_o, 7'h00);
    @(negedge test_clk);
    rst_n = 1'b1;
    #3;
    chk("R8", "still off before first edge", oe_o, 7'h00);
    @(posedge test_clk);
    check_test_window(14);
  endtask

  task automatic run_change_timing();
    apply_sel(2'b10);
    @(negedge test_clk);
    sel_i = 2'b00;
    #5;
    chk("R7", "old mode held until edge", oe_o, 7'h7f);
    @(posedge test_clk);
    #2;
    chk("R7", "new mode after edge", oe_o, 7'h00);
  endtask

  initial begin
    run_reset();
    run_normal(2'b10, "R5");
    run_normal(2'b11, "R6");
    apply_sel(2'b01);
    check_test_window(8);
    run_off();
    apply_sel(2'b01);
    check_test_window(7);
    run_change_timing();
    apply_sel(2'b01);
    check_test_window(13);
    run_normal(2'b11, "R6");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule